// File: doc/BRIEF.md
# Standby and Wake-up Mode Controller

This block decides when a small microcontroller runs, dozes or halts its oscillator. Software writes a standby control word. One bit asks for a light doze (sleep). A second bit asks for a full halt (stop). A third bit chooses whether the pins float or hold during a halt. A two-bit field selects how long the oscillator is given to settle when the chip leaves a halt. From the mode it is in, the controller drives an oscillator enable, a CPU clock gate, a peripheral clock gate and two pin controls.

Sleep ends on a reset request or on any interrupt whose priority level reaches the wake threshold. The controller returns to run in the following cycle. Stop ends only on a reset request or on a qualifying external interrupt, because internal sources have no clock during a halt. Each exit from stop passes through a counted oscillator settling wait. When a reset causes the exit, the reset is held on the rest of the chip until the wait has run out. An interrupt that is pending at the moment the halt is requested cancels that request. The controller does not decide whether the CPU accepts the interrupt.

Top module: `stby_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode` is run (0) and `osc_en`, `cpu_clk_en`, `per_clk_en` and `rst_release` are 1, while `pin_hiz`, `pin_hold` and `wake_pulse` are 0. The selected pin option and the wait field are both 0.
- R2: The control word has these bits. Bit 0 requests stop, bit 1 requests sleep, bit 2 selects floating pins and bits 4:3 select the wait. Suppose a write with bit 0 set arrives in run, with no interrupt line active and no reset request. On the next clock `mode` is stop (2) and `osc_en`, `cpu_clk_en` and `per_clk_en` are 0.
- R3: Suppose any internal interrupt line or the external interrupt is active, at any level, when bit 0 is written. The controller then stays in run with the oscillator on.
- R4: A write of bit 1 alone in run gives sleep (1) on the next clock. In sleep `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R5: A write with bits 0 and 1 both set enters stop, not sleep.
- R6: In sleep, a reset request or any interrupt (internal or external) of level 7 or above returns `mode` to run on the next clock. Levels 0 to 6 leave the controller in sleep.
- R7: In stop, internal interrupt lines of every level are ignored, and so is an external interrupt below level 7. `mode` stays stop and `osc_en` stays 0.
- R8: In stop, an external interrupt of level 7 or above moves `mode` to the settling wait (3) on the next clock. In the wait `osc_en` is 1 and `cpu_clk_en` is 0. `mode` becomes run exactly N clocks later, where N is 16, 1024, 8192 or 32768 for wait field 0, 1, 2 or 3.
- R9: A reset request in stop also enters the settling wait for the same N. `rst_release` stays 0 throughout the wait and returns to 1 in the same cycle as run, provided the request has been removed by then. In sleep, a reset request makes `rst_release` 0 for one cycle.
- R10: In stop and in the settling wait, `pin_hiz` is 1 if the float bit was 1 when the stop was written. Otherwise `pin_hold` is 1. In run and sleep both are 0.
- R11: `wake_pulse` is 1 for exactly the first cycle of run after sleep or after the settling wait. The stop and sleep requests clear themselves, so the controller stays in run afterwards.
- R12: Writes made outside run have no effect on the mode. A write in run with neither bit 0 nor bit 1 set keeps `mode` at run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_req | input | 1 | Chip reset request; also a wake source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word: stop, sleep, float, wait select[1:0] |
| irq_req | input | NIRQ | Internal interrupt request lines |
| irq_lvl | input | NIRQ*LVL_W | Priority level of each internal line, line i at bits i*LVL_W upward |
| ext_irq_req | input | 1 | External interrupt request |
| ext_irq_lvl | input | LVL_W | Priority level of the external interrupt |
| mode | output | 2 | 0 run, 1 sleep, 2 stop, 3 settling wait |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pin_hiz | output | 1 | Put the external pins in high impedance |
| pin_hold | output | 1 | Hold the external pins at their last values |
| wake_pulse | output | 1 | One-cycle pulse on return to run |
| rst_release | output | 1 | 1 when the chip reset is released |

## Verification
Every result registers on one clock edge. The bench drives its inputs at the falling edge, so a write, an interrupt or a reset request takes effect at the next rising edge and is sampled at the falling edge after that. This holds for entry into sleep, stop and the wait, for sleep exit and for stop cancellation. The settling wait is measured by counting falling edges from the first sample of mode 3 until run appears. The count must equal 16, 1024, 8192 or 32768 exactly. `wake_pulse` and `rst_release` are checked at that same sample and again one cycle later.

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
  parameter int NIRQ     = 4,
  parameter int LVL_W    = 4,
  parameter int WAKE_LVL = 7,
  parameter int EXP0     = 4,
  parameter int EXP1     = 10,
  parameter int EXP2     = 13,
  parameter int EXP3     = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sys_rst_req,
  input  logic                  wr_en,
  input  logic [4:0]            wr_data,
  input  logic [NIRQ-1:0]       irq_req,
  input  logic [NIRQ*LVL_W-1:0] irq_lvl,
  input  logic                  ext_irq_req,
  input  logic [LVL_W-1:0]      ext_irq_lvl,
  output logic [1:0]            mode,
  output logic                  osc_en,
  output logic                  cpu_clk_en,
  output logic                  per_clk_en,
  output logic                  pin_hiz,
  output logic                  pin_hold,
  output logic                  wake_pulse,
  output logic                  rst_release
);
  localparam int CNT_W = EXP3;

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_SLP = 2'd1, ST_STP = 2'd2, ST_OSW = 2'd3} st_t;

  st_t              state, nxt;
  logic [CNT_W-1:0] cnt, reload;
  logic [1:0]       osc_sel;
  logic             hiz_sel, rst_hold_q, wake_q;
  logic             int_any, int_wake, ext_wake, any_irq, stop_cond, run_wr;

  always_comb begin
    int_any  = 1'b0;
    int_wake = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      int_any = int_any | irq_req[i];
      if (irq_req[i] && irq_lvl[i*LVL_W +: LVL_W] >= LVL_W'(WAKE_LVL))
        int_wake = 1'b1;
    end
  end

  assign ext_wake  = ext_irq_req && (ext_irq_lvl >= LVL_W'(WAKE_LVL));
  assign any_irq   = int_any | ext_irq_req;
  assign run_wr    = (state == ST_RUN) && wr_en && !sys_rst_req;
  assign stop_cond = (state == ST_STP) || (state == ST_OSW);

  always_comb begin
    case (osc_sel)
      2'd0:    reload = CNT_W'((64'd1 << EXP0) - 64'd1);
      2'd1:    reload = CNT_W'((64'd1 << EXP1) - 64'd1);
      2'd2:    reload = CNT_W'((64'd1 << EXP2) - 64'd1);
      default: reload = CNT_W'((64'd1 << EXP3) - 64'd1);
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN: if (run_wr && wr_data[0]) nxt = any_irq ? ST_RUN : ST_STP;
              else if (run_wr && wr_data[1]) nxt = ST_SLP;
      ST_SLP: if (sys_rst_req || int_wake || ext_wake) nxt = ST_RUN;
      ST_STP: if (sys_rst_req || ext_wake) nxt = ST_OSW;
      default: if (cnt == '0) nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      cnt        <= '0;
      osc_sel    <= 2'd0;
      hiz_sel    <= 1'b0;
      rst_hold_q <= 1'b0;
      wake_q     <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_STP && nxt == ST_OSW) cnt <= reload;
      else if (state == ST_OSW && cnt != '0) cnt <= cnt - 1'b1;
      if (run_wr) begin
        hiz_sel <= wr_data[2];
        osc_sel <= wr_data[4:3];
      end
      rst_hold_q <= sys_rst_req | (rst_hold_q & (nxt == ST_STP || nxt == ST_OSW));
      wake_q     <= (state == ST_SLP || state == ST_OSW) && nxt == ST_RUN;
    end
  end

  assign mode        = state;
  assign osc_en      = state != ST_STP;
  assign cpu_clk_en  = state == ST_RUN;
  assign per_clk_en  = state == ST_RUN || state == ST_SLP;
  assign pin_hiz     = stop_cond && hiz_sel;
  assign pin_hold    = stop_cond && !hiz_sel;
  assign wake_pulse  = wake_q;
  assign rst_release = !rst_hold_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
  parameter int NIRQ     = 4,
  parameter int LVL_W    = 4,
  parameter int WAKE_LVL = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_req,
  input logic             wr_en,
  input logic [4:0]       wr_data,
  input logic             int_any,
  input logic             int_wake,
  input logic             ext_irq_req,
  input logic [LVL_W-1:0] ext_irq_lvl,
  input logic [1:0]       mode,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             wake_pulse,
  input logic             rst_release
);
  logic ext_ok, stop_wr;
  assign ext_ok  = ext_irq_req && (ext_irq_lvl >= LVL_W'(WAKE_LVL));
  assign stop_wr = (mode == 2'd0) && wr_en && wr_data[0] && !sys_rst_req;

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !int_any && !ext_irq_req) |=> (mode == 2'd2 && !osc_en && !cpu_clk_en));

  assert_stop_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && (int_any || ext_irq_req)) |=> (mode == 2'd0));

  assert_stop_over_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && wr_data[1] && !int_any && !ext_irq_req) |=> (mode == 2'd2));

  assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && (int_wake || ext_ok || sys_rst_req)) |=> (mode == 2'd0 && wake_pulse));

  assert_stop_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !sys_rst_req && !ext_ok) |=> (mode == 2'd2));

  assert_wait_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> (mode == 2'd3 || mode == 2'd0));

  assert_release_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_release) |-> (mode == 2'd0));

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
endmodule

bind stby_ctrl stby_ctrl_chk #(.NIRQ(NIRQ), .LVL_W(LVL_W), .WAKE_LVL(WAKE_LVL)) chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .wr_en(wr_en), .wr_data(wr_data),
  .int_any(int_any), .int_wake(int_wake), .ext_irq_req(ext_irq_req), .ext_irq_lvl(ext_irq_lvl),
  .mode(mode), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .wake_pulse(wake_pulse),
  .rst_release(rst_release));

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NIRQ  = 4;
  localparam int LVL_W = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  sys_rst_req = 1'b0;
  logic                  wr_en = 1'b0;
  logic [4:0]            wr_data = '0;
  logic [NIRQ-1:0]       irq_req = '0;
  logic [NIRQ*LVL_W-1:0] irq_lvl = '0;
  logic                  ext_irq_req = 1'b0;
  logic [LVL_W-1:0]      ext_irq_lvl = '0;
  logic [1:0]            mode;
  logic osc_en, cpu_clk_en, per_clk_en, pin_hiz, pin_hold, wake_pulse, rst_release;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stby_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .wr_en(wr_en), .wr_data(wr_data),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .ext_irq_req(ext_irq_req), .ext_irq_lvl(ext_irq_lvl),
    .mode(mode), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .pin_hiz(pin_hiz), .pin_hold(pin_hold), .wake_pulse(wake_pulse), .rst_release(rst_release));

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic int wait_len(input int s);
    case (s)
      0: return 16;
      1: return 1024;
      2: return 8192;
      default: return 32768;
    endcase
  endfunction

  task automatic ext_wake();
    ext_irq_req = 1'b1;
    ext_irq_lvl = 4'd7;
    step();
    ext_irq_req = 1'b0;
    ext_irq_lvl = '0;
  endtask

  task automatic wait_run(output int n, output bit rel_bad);
    n = 0;
    rel_bad = 1'b0;
    while (mode != 2'd0 && n < 40000) begin
      if (rst_release) rel_bad = 1'b1;
      step();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    bit rb;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    check("R1 mode", mode, 0);
    check("R1 osc_en", osc_en, 1);
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 per_clk_en", per_clk_en, 1);
    check("R1 rst_release", rst_release, 1);
    check("R1 pins", {pin_hiz, pin_hold}, 0);
    check("R1 wake_pulse", wake_pulse, 0);

    wr(5'b11100);
    check("R12 write without mode bits", mode, 0);

    for (int src = 0; src < 2; src++) begin
      for (int lv = 0; lv < 16; lv++) begin
        wr(5'b00010);
        check("R4 sleep mode", mode, 1);
        check("R4 sleep clocks", {osc_en, cpu_clk_en, per_clk_en}, 3'b101);
        check("R10 pins in sleep", {pin_hiz, pin_hold}, 0);
        if (src == 0) begin
          irq_req[lv % NIRQ] = 1'b1;
          irq_lvl[(lv % NIRQ)*LVL_W +: LVL_W] = LVL_W'(lv);
        end else begin
          ext_irq_req = 1'b1;
          ext_irq_lvl = LVL_W'(lv);
        end
        step();
        irq_req = '0;
        irq_lvl = '0;
        ext_irq_req = 1'b0;
        ext_irq_lvl = '0;
        check("R6 sleep exit by level", mode, (lv >= 7) ? 0 : 1);
        if (lv >= 7) check("R11 pulse after sleep", wake_pulse, 1);
        else begin
          ext_wake();
          check("R6 sleep exit level 7", mode, 0);
        end
        step();
        check("R11 pulse ends, stays run", {wake_pulse, mode}, 0);
      end
    end

    wr(5'b00010);
    wr(5'b11001);
    check("R12 write in sleep ignored", mode, 1);
    sys_rst_req = 1'b1;
    step();
    sys_rst_req = 1'b0;
    check("R9 reset wakes sleep", mode, 0);
    check("R9 reset held in sleep exit", rst_release, 0);
    step();
    check("R9 reset released", rst_release, 1);

    for (int i = 0; i <= NIRQ; i++) begin
      for (int k = 0; k < 2; k++) begin
        if (i < NIRQ) begin
          irq_req[i] = 1'b1;
          irq_lvl[i*LVL_W +: LVL_W] = (k == 0) ? 4'd0 : 4'd15;
        end else begin
          ext_irq_req = 1'b1;
          ext_irq_lvl = (k == 0) ? 4'd0 : 4'd15;
        end
        wr(5'b00001);
        irq_req = '0;
        irq_lvl = '0;
        ext_irq_req = 1'b0;
        ext_irq_lvl = '0;
        check("R3 stop cancelled", mode, 0);
        check("R3 oscillator kept", osc_en, 1);
        step();
      end
    end

    wr(5'b00011);
    check("R5 stop beats sleep", mode, 2);
    check("R2 stop clocks off", {osc_en, cpu_clk_en, per_clk_en}, 0);
    irq_req = '1;
    irq_lvl = '1;
    repeat (3) step();
    irq_req = '0;
    irq_lvl = '0;
    check("R7 internal lines ignored", mode, 2);
    check("R7 oscillator stays off", osc_en, 0);
    ext_irq_req = 1'b1;
    ext_irq_lvl = 4'd6;
    step();
    ext_irq_req = 1'b0;
    check("R7 external level 6 ignored", mode, 2);
    ext_wake();
    check("R8 wait entered", mode, 3);
    wait_run(n, rb);
    check("R8 wait length select 0", n, 16);
    step();

    for (int sel = 0; sel < 4; sel++) begin
      for (int src = 0; src < 2; src++) begin
        wr({sel[1:0], src[0], 2'b01});
        check("R2 stop mode", mode, 2);
        check("R10 stop pin hiz", pin_hiz, src);
        check("R10 stop pin hold", pin_hold, 1 - src);
        if (src == 0) begin
          ext_irq_req = 1'b1;
          ext_irq_lvl = LVL_W'(7 + sel);
        end else sys_rst_req = 1'b1;
        step();
        ext_irq_req = 1'b0;
        ext_irq_lvl = '0;
        sys_rst_req = 1'b0;
        check("R8 wait state", mode, 3);
        check("R8 wait clocks", {osc_en, cpu_clk_en}, 2'b10);
        check("R10 pins kept in wait", {pin_hiz, pin_hold}, (src == 1) ? 2 : 1);
        check("R9 reset hold at wait start", rst_release, 1 - src);
        wait_run(n, rb);
        check("R8 wait length", n, wait_len(sel));
        if (src == 1) check("R9 reset held for whole wait", rb, 0);
        check("R9 release with run", rst_release, 1);
        check("R11 pulse after wait", wake_pulse, 1);
        check("R10 pins normal in run", {pin_hiz, pin_hold}, 0);
        check("R8 cpu clock back", cpu_clk_en, 1);
        step();
        check("R11 pulse ends, stays run", {wake_pulse, mode}, 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule